// File: doc/BRIEF.md
# Segmented Scan-In Mode Sequencer

This block steers the filter selection of a built-in pattern generator while a pattern is shifted into a set of parallel scan chains. Each scan-in of `CHAIN_LEN` bits is cut into three consecutive windows: a leading low-toggle window fed from the filtered stream, a middle window fed with raw random bits, and a trailing low-toggle window. One select bit per chain tells the generator which stream to use for the bit about to be shifted.

The leading and middle window lengths are captured from configuration inputs on a load strobe. The trailing length is whatever remains of the chain. An external test controller supplies the shift enable and an end-of-pattern strobe. At every pattern boundary the window positions are re-planned by one of three policies. Fixed keeps them. Swap gives odd-indexed chains the mirror of the even-indexed layout and exchanges the two on each new pattern. Slide moves the random window one bit toward the chain entry on each pattern, and restarts it from its loaded position once the leading window would become too short to filter.

Top module: `scan_seg_mode_seq`

## Requirements
- R1: While reset is active, and right after it, every bit of `filt_sel_o` is 1. A 1 means filtered and a 0 means raw.
- R2: With shift counter value c, leading length a and middle length m for a chain, that chain's select is 0 exactly when a <= c < a+m, and is 1 otherwise. The select for bit c is present before the shift edge that consumes bit c, and it changes on the same edge that advances the counter.
- R3: After `CHAIN_LEN` shifts, the counter holds at `CHAIN_LEN`, all selects are 1, and further shift pulses change nothing.
- R4: `pattern_done_i` returns the counter to 0 on the next edge, even if shifting stopped part-way through the pattern.
- R5: Under policy code 0 (fixed), and under the unused code 3, every chain uses the loaded leading length on every pattern.
- R6: Under policy code 1 (swap), even-indexed chains (0, 2, ...) use leading length a, and odd-indexed chains use `CHAIN_LEN`-a-m. At each pattern boundary, a is replaced by `CHAIN_LEN`-a-m.
- R7: Under policy code 2 (slide), each pattern boundary reduces the leading length by 1. If the current leading length is already `MIN_FILT` or less, it reloads the loaded value instead.
- R8: `cfg_load_i` captures `lead_len_i`, `mid_len_i` and `policy_i` and clears the counter. When it coincides with `pattern_done_i`, the load takes priority.
- R9: With no shift, no pattern strobe and no load, the counter and all selects hold.
- R10: Changes on the configuration inputs without `cfg_load_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shift_en_i | input | 1 | One scan-shift cycle is taken at this edge |
| pattern_done_i | input | 1 | End of pattern; re-plan windows, restart count |
| cfg_load_i | input | 1 | Capture configuration and restart count |
| lead_len_i | input | CW | Leading filtered window length |
| mid_len_i | input | CW | Random middle window length |
| policy_i | input | 2 | 0 fixed, 1 swap, 2 slide, 3 fixed |
| filt_sel_o | output | NUM_CHAINS | Per-chain select, 1 filtered, 0 raw |

## Verification
Full patterns are shifted under each policy, and the select of every chain is compared bit by bit against a layout model. Fixed runs with an unloaded input change show that the layout persists. Swap runs show the even and odd chains diverging and trading places on each pattern. A four-pattern slide run crosses the reload floor. Stall cycles inside a pattern, extra shifts past the chain end, an abort in the middle window, and a load coinciding with an end-of-pattern strobe separate hold, saturation, restart and priority behaviour.

// File: rtl/scan_seg_pkg.sv
package scan_seg_pkg;
  typedef enum logic [1:0] {
    POL_FIXED = 2'd0,
    POL_SWAP  = 2'd1,
    POL_SLIDE = 2'd2,
    POL_RSVD  = 2'd3
  } policy_e;
endpackage

// File: rtl/scan_seg_ctr.sv
module scan_seg_ctr #(
  parameter int unsigned CHAIN_LEN = 76,
  parameter int unsigned CW        = $clog2(CHAIN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  output logic [CW-1:0] cnt_nxt_o
);
  localparam logic [CW-1:0] LAST = CW'(CHAIN_LEN);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                        cnt_d = '0;
    else if (shift_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_nxt_o = cnt_d;
endmodule

// File: rtl/scan_seg_plan.sv
module scan_seg_plan
  import scan_seg_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 76,
  parameter int unsigned MIN_FILT  = 14,
  parameter int unsigned CW        = $clog2(CHAIN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          boundary_i,
  input  logic [CW-1:0] lead_cfg_i,
  input  logic [CW-1:0] mid_cfg_i,
  input  logic [1:0]    pol_cfg_i,
  output logic [CW-1:0] lead_nxt_o,
  output logic [CW-1:0] mid_nxt_o,
  output policy_e       pol_nxt_o
);
  localparam logic [CW-1:0] LEN   = CW'(CHAIN_LEN);
  localparam logic [CW-1:0] FLOOR = CW'(MIN_FILT);

  logic [CW-1:0] lead_q, lead_d, mid_q, mid_d, init_q, init_d;
  policy_e       pol_q, pol_d;

  always_comb begin
    lead_d = lead_q;
    mid_d  = mid_q;
    init_d = init_q;
    pol_d  = pol_q;
    if (load_i) begin
      lead_d = lead_cfg_i;
      init_d = lead_cfg_i;
      mid_d  = mid_cfg_i;
      pol_d  = policy_e'(pol_cfg_i);
    end else if (boundary_i) begin
      unique case (pol_q)
        POL_SWAP:  lead_d = LEN - lead_q - mid_q;
        POL_SLIDE: lead_d = (lead_q <= FLOOR) ? init_q : lead_q - 1'b1;
        default:   lead_d = lead_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lead_q <= '0;
      mid_q  <= '0;
      init_q <= '0;
      pol_q  <= POL_FIXED;
    end else begin
      lead_q <= lead_d;
      mid_q  <= mid_d;
      init_q <= init_d;
      pol_q  <= pol_d;
    end
  end

  assign lead_nxt_o = lead_d;
  assign mid_nxt_o  = mid_d;
  assign pol_nxt_o  = pol_d;
endmodule

// File: rtl/scan_seg_decode.sv
module scan_seg_decode #(
  parameter int unsigned CW = 7
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] lead_i,
  input  logic [CW-1:0] mid_i,
  output logic          filt_o
);
  logic [CW:0] end_w;
  logic        raw;

  assign end_w  = {1'b0, lead_i} + {1'b0, mid_i};
  assign raw    = (cnt_i >= lead_i) && ({1'b0, cnt_i} < end_w);
  assign filt_o = ~raw;
endmodule

// File: rtl/scan_seg_mode_seq.sv
module scan_seg_mode_seq
  import scan_seg_pkg::*;
#(
  parameter int unsigned CHAIN_LEN  = 76,
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned MIN_FILT   = 14,
  parameter int unsigned CW         = $clog2(CHAIN_LEN + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_en_i,
  input  logic                  pattern_done_i,
  input  logic                  cfg_load_i,
  input  logic [CW-1:0]         lead_len_i,
  input  logic [CW-1:0]         mid_len_i,
  input  logic [1:0]            policy_i,
  output logic [NUM_CHAINS-1:0] filt_sel_o
);
  logic [CW-1:0]         cnt_nxt, lead_nxt, mid_nxt, mirror_nxt;
  policy_e               pol_nxt;
  logic [NUM_CHAINS-1:0] filt_d, filt_q;

  scan_seg_ctr #(.CHAIN_LEN(CHAIN_LEN), .CW(CW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (cfg_load_i | pattern_done_i),
    .shift_i   (shift_en_i),
    .cnt_nxt_o (cnt_nxt)
  );

  scan_seg_plan #(.CHAIN_LEN(CHAIN_LEN), .MIN_FILT(MIN_FILT), .CW(CW)) u_plan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_load_i),
    .boundary_i (pattern_done_i),
    .lead_cfg_i (lead_len_i),
    .mid_cfg_i  (mid_len_i),
    .pol_cfg_i  (policy_i),
    .lead_nxt_o (lead_nxt),
    .mid_nxt_o  (mid_nxt),
    .pol_nxt_o  (pol_nxt)
  );

  // layout used by odd chains in swap mode
  assign mirror_nxt = CW'(CHAIN_LEN) - lead_nxt - mid_nxt;

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
    logic [CW-1:0] lead_sel;
    if (g % 2 == 1) begin : g_odd
      assign lead_sel = (pol_nxt == POL_SWAP) ? mirror_nxt : lead_nxt;
    end else begin : g_even
      assign lead_sel = lead_nxt;
    end
    scan_seg_decode #(.CW(CW)) u_dec (
      .cnt_i  (cnt_nxt),
      .lead_i (lead_sel),
      .mid_i  (mid_nxt),
      .filt_o (filt_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) filt_q <= '1;
    else         filt_q <= filt_d;
  end

  assign filt_sel_o = filt_q;
endmodule

// File: rtl/scan_seg_mode_seq_chk.sv
module scan_seg_mode_seq_chk #(
  parameter int unsigned CHAIN_LEN  = 76,
  parameter int unsigned NUM_CHAINS = 4,
  parameter int unsigned CW         = 7
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  shift_en_i,
  input logic                  pattern_done_i,
  input logic                  cfg_load_i,
  input logic [CW-1:0]         cnt_nxt_i,
  input logic [NUM_CHAINS-1:0] filt_i
);
  function automatic logic [NUM_CHAINS-1:0] even_mask();
    logic [NUM_CHAINS-1:0] m = '0;
    for (int i = 0; i < NUM_CHAINS; i += 2) m[i] = 1'b1;
    return m;
  endfunction
  localparam logic [NUM_CHAINS-1:0] EVEN_M = even_mask();
  localparam logic [NUM_CHAINS-1:0] ODD_M  = ~EVEN_M;

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_nxt_i <= CW'(CHAIN_LEN));

  a_r3_tail_filtered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_nxt_i == CW'(CHAIN_LEN)) |=> (&filt_i));

  a_r4_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pattern_done_i |-> (cnt_nxt_i == '0));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_en_i && !pattern_done_i && !cfg_load_i) |=> $stable(filt_i));

  // R2: chains sharing a parity always share a layout
  a_r2_parity_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((filt_i & EVEN_M) == '0 || (filt_i & EVEN_M) == EVEN_M) &&
    ((filt_i & ODD_M) == '0 || (filt_i & ODD_M) == ODD_M));
endmodule

bind scan_seg_mode_seq scan_seg_mode_seq_chk #(
  .CHAIN_LEN (CHAIN_LEN),
  .NUM_CHAINS(NUM_CHAINS),
  .CW        (CW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .shift_en_i     (shift_en_i),
  .pattern_done_i (pattern_done_i),
  .cfg_load_i     (cfg_load_i),
  .cnt_nxt_i      (cnt_nxt),
  .filt_i         (filt_sel_o)
);

// File: tb/tb_scan_seg_mode_seq.sv
`timescale 1ns/1ps
module tb_scan_seg_mode_seq;
  localparam int L  = 76;
  localparam int NC = 4;
  localparam int CW = $clog2(L + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          shift_en_i = 1'b0;
  logic          pattern_done_i = 1'b0;
  logic          cfg_load_i = 1'b0;
  logic [CW-1:0] lead_len_i = '0;
  logic [CW-1:0] mid_len_i = '0;
  logic [1:0]    policy_i = 2'd0;
  logic [NC-1:0] filt_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk_i = ~clk_i;

  scan_seg_mode_seq #(.CHAIN_LEN(L), .NUM_CHAINS(NC), .MIN_FILT(14)) dut (.*);

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input logic got, input logic exp, input string req, input int ch, input int c);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s chain %0d bit %0d: got %b exp %b", req, ch, c, got, exp);
    end
  endtask

  function automatic logic exp_sel(input int c, input int a, input int m);
    return !(c >= a && c < a + m);
  endfunction

  task automatic check_all(input int c, input int a_ev, input int a_od, input int m, input string req);
    for (int g = 0; g < NC; g++)
      chk(filt_sel_o[g], exp_sel(c, (g % 2 == 0) ? a_ev : a_od, m), req, g, c);
  endtask

  task automatic load(input int a, input int m, input int pol);
    lead_len_i = CW'(a); mid_len_i = CW'(m); policy_i = 2'(pol);
    cfg_load_i = 1'b1;
    tick();
    cfg_load_i = 1'b0;
  endtask

  task automatic boundary();
    pattern_done_i = 1'b1;
    tick();
    pattern_done_i = 1'b0;
  endtask

  task automatic shift1();
    shift_en_i = 1'b1;
    tick();
    shift_en_i = 1'b0;
  endtask

  // full pattern: every bit checked before its shift, then saturation
  task automatic run_pat(input int a_ev, input int a_od, input int m, input string req, input bit gaps);
    for (int c = 0; c < L; c++) begin
      check_all(c, a_ev, a_od, m, req);
      if (gaps && (c % 7 == 3)) begin
        tick();
        check_all(c, a_ev, a_od, m, "R9");
      end
      shift1();
    end
    check_all(L, a_ev, a_od, m, "R3");
    shift1();
    shift1();
    check_all(L, a_ev, a_od, m, "R3");
  endtask

  task automatic t_reset();
    #3;
    for (int g = 0; g < NC; g++) chk(filt_sel_o[g], 1'b1, "R1", g, 0);
    tick();
    rst_ni = 1'b1;
    tick();
    for (int g = 0; g < NC; g++) chk(filt_sel_o[g], 1'b1, "R1", g, 0);
  endtask

  task automatic t_fixed();
    load(28, 19, 0);
    run_pat(28, 28, 19, "R2", 1'b1);
    boundary();
    lead_len_i = CW'(5); mid_len_i = CW'(40); policy_i = 2'd1;  // R10: not loaded
    run_pat(28, 28, 19, "R10", 1'b0);
    boundary();
    run_pat(28, 28, 19, "R5", 1'b0);
    load(20, 15, 3);
    boundary();
    run_pat(20, 20, 15, "R5", 1'b0);
    boundary();
  endtask

  task automatic t_swap();
    load(28, 19, 1);
    run_pat(28, 29, 19, "R6", 1'b0);
    boundary();
    run_pat(29, 28, 19, "R6", 1'b0);
    boundary();
    run_pat(28, 29, 19, "R6", 1'b0);
    boundary();
  endtask

  task automatic t_slide();
    load(16, 20, 2);
    run_pat(16, 16, 20, "R7", 1'b0);
    boundary();
    run_pat(15, 15, 20, "R7", 1'b0);
    boundary();
    run_pat(14, 14, 20, "R7", 1'b0);
    boundary();
    run_pat(16, 16, 20, "R7", 1'b0);
    boundary();
  endtask

  task automatic t_abort();
    load(30, 10, 0);
    for (int c = 0; c < 35; c++) shift1();
    check_all(35, 30, 30, 10, "R4");
    boundary();
    run_pat(30, 30, 10, "R4", 1'b0);
  endtask

  task automatic t_priority();
    load(10, 30, 2);
    for (int c = 0; c < 20; c++) shift1();
    lead_len_i = CW'(40); mid_len_i = CW'(20); policy_i = 2'd0;
    cfg_load_i = 1'b1;
    pattern_done_i = 1'b1;
    tick();
    cfg_load_i = 1'b0;
    pattern_done_i = 1'b0;
    run_pat(40, 40, 20, "R8", 1'b0);
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_swap();
    t_slide();
    t_abort();
    t_priority();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule